// File: doc/BRIEF.md
# Single-Bit ECC Compare and Correct

This block checks one 512-byte NAND data block against its single-bit error-correcting code. The parity generator supplies two raw 12-bit parity halves. The block packs them into a 24-bit code and inverts the code, so that an erased page, with all ones in both data and spare, checks clean. It then compares this code with the 24-bit code read back from the spare area. The comparison gives one of four results: a clean block, a single flipped data bit that can be repaired, a flipped bit inside the stored code itself, or damage that cannot be repaired. For a repairable error the block also reports the byte position and a one-hot bit mask.

The block holds the location of the last repairable error. It applies the fix to a byte stream that passes through it. After a result, the caller streams the block's bytes in order from position 0. The byte at the reported position leaves with the faulty bit flipped, and every other byte passes unchanged.

The stream runs straight through the block with no storage. `m_valid` follows `s_valid` and `s_ready` follows `m_ready` in the same cycle. A byte counts as transferred only in a cycle where both valid and ready are high. While the consumer holds `m_ready` low, the producer sees `s_ready` low and must hold its byte, and the position counter does not move.

Top module: `ecc1_corrector`

## Requirements
- R1: The computed code is `~{calc_hi, calc_lo}`, with the low half in bits 11:0 and the high half in bits 23:12. `stored_code` carries the three spare bytes with the first byte in bits 7:0, the second in bits 15:8 and the third in bits 23:16.
- R2: A result appears with `res_valid` high in the cycle after `code_valid` is sampled high. `res_valid` is high for exactly that one cycle per request.
- R3: When the computed code equals `stored_code`, `res_status` is 2'b00.
- R4: Let diff be the computed code XOR `stored_code`. When diff[23:12] XOR diff[11:0] is 12'hFFF and diff[23:15] is below BLOCK_BYTES, `res_status` is 2'b01. `res_byte` is then diff[23:15] and `res_mask` is 1 shifted left by diff[14:12].
- R5: When the halves are exact complements but diff[23:15] is not below BLOCK_BYTES, `res_status` is 2'b11.
- R6: When diff has exactly one bit set, `res_status` is 2'b10, `res_byte` and `res_mask` are zero, and no stream byte is altered.
- R7: Any other nonzero diff gives `res_status` 2'b11, with `res_byte` and `res_mask` zero.
- R8: After a 2'b01 result, the byte transferred at position `res_byte` leaves XORed with `res_mask`. Positions count transfers from 0, starting after that result. Every other byte passes unchanged.
- R9: `m_valid` equals `s_valid`, `s_ready` equals `m_ready`, and the stream position advances only on a cycle in which both valid and ready are high.
- R10: After reset, `res_valid` is low, `res_status` is 2'b00 and the stream passes unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_valid | input | 1 | Code pair present; starts a compare |
| calc_lo | input | 12 | Raw low parity half from the generator |
| calc_hi | input | 12 | Raw high parity half from the generator |
| stored_code | input | 24 | Code read from spare, first byte in bits 7:0 |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 2 | 00 clean, 01 data fixed, 10 code bit, 11 uncorrectable |
| res_byte | output | 9 | Position of the faulty byte (zero unless status 01) |
| res_mask | output | 8 | One-hot faulty bit (zero unless status 01) |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream ready |
| s_data | input | 8 | Upstream byte |
| m_valid | output | 1 | Downstream byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Downstream byte, fixed where required |

## Verification
The compare is driven with a matched code pair built from distinct, asymmetric halves. This shows that halves or bytes have not been swapped. It also tells a clean result apart from a packing or inversion mistake. Diffs with complementary halves are tried at byte 5 and at byte 511. The first checks the index and mask extraction. The second, with a second instance sized at 256 bytes, separates the in-range repair from the out-of-range rejection. Single-bit diffs at both ends of the code and multi-bit diffs that are not complements separate a code-bit error from an uncorrectable one. A stream with stall cycles then shows that the fix lands at the right position only when transfers really occur.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = CODE_W - HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_CODE  = 2'b10,
    ST_BAD   = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc1_pack.sv
module ecc1_pack
  import ecc1_pkg::*;
(
  input  logic [HALF_W-1:0] half_lo,
  input  logic [HALF_W-1:0] half_hi,
  output logic [CODE_W-1:0] code
);
  // inverted so that an erased page (all ones) compares clean
  assign code = ~{half_hi, half_lo};
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output ecc_status_e       status,
  output logic [IDX_W-1:0]  err_idx,
  output logic [BYTE_W-1:0] err_mask
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(BLOCK_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic              in_range;

  assign diff     = calc_code ^ stored_code;
  assign fold     = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign err_idx  = diff[CODE_W-1:HALF_W+BIT_W];
  assign err_mask = BYTE_W'(1) << diff[HALF_W+BIT_W-1:HALF_W];
  assign in_range = {1'b0, err_idx} < LIMIT;

  always_comb begin
    if (diff == '0)
      status = ST_CLEAN;
    else if (fold == '1)
      status = in_range ? ST_FIXED : ST_BAD;
    else if ($countones(diff) == 1)
      status = ST_CODE;
    else
      status = ST_BAD;
  end
endmodule

// File: rtl/ecc1_fix.sv
module ecc1_fix
  import ecc1_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              arm,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] mask,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data
);
  localparam int CNT_W = $clog2(BLOCK_BYTES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLOCK_BYTES);

  logic              armed;
  logic [IDX_W-1:0]  fix_idx;
  logic [BYTE_W-1:0] fix_mask;
  logic [CNT_W-1:0]  pos;
  logic              fire;
  logic              hit;

  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign fire    = s_valid && m_ready;
  assign hit     = armed && (int'(pos) == int'(fix_idx));
  assign m_data  = hit ? (s_data ^ fix_mask) : s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      fix_idx  <= '0;
      fix_mask <= '0;
      pos      <= '0;
    end else if (load) begin
      armed    <= arm;
      fix_idx  <= idx;
      fix_mask <= mask;
      pos      <= '0;
    end else if (fire && pos != CNT_MAX) begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/ecc1_corrector.sv
module ecc1_corrector
  import ecc1_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        code_valid,
  input  logic [11:0] calc_lo,
  input  logic [11:0] calc_hi,
  input  logic [23:0] stored_code,
  output logic        res_valid,
  output logic [1:0]  res_status,
  output logic [8:0]  res_byte,
  output logic [7:0]  res_mask,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data
);
  logic [CODE_W-1:0] calc_code;
  ecc_status_e       cls_status;
  logic [IDX_W-1:0]  cls_idx;
  logic [BYTE_W-1:0] cls_mask;
  logic              is_fixed;

  ecc1_pack pack_i (
    .half_lo (calc_lo),
    .half_hi (calc_hi),
    .code    (calc_code)
  );

  ecc1_classify #(.BLOCK_BYTES(BLOCK_BYTES)) cls_i (
    .calc_code   (calc_code),
    .stored_code (stored_code),
    .status      (cls_status),
    .err_idx     (cls_idx),
    .err_mask    (cls_mask)
  );

  assign is_fixed = (cls_status == ST_FIXED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      res_byte   <= '0;
      res_mask   <= '0;
    end else begin
      res_valid <= code_valid;
      if (code_valid) begin
        res_status <= cls_status;
        res_byte   <= is_fixed ? cls_idx  : '0;
        res_mask   <= is_fixed ? cls_mask : '0;
      end
    end
  end

  ecc1_fix #(.BLOCK_BYTES(BLOCK_BYTES)) fix_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (code_valid),
    .arm     (is_fixed),
    .idx     (cls_idx),
    .mask    (cls_mask),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );
endmodule

// File: rtl/ecc1_corrector_chk.sv
module ecc1_corrector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        code_valid,
  input logic [11:0] calc_lo,
  input logic [11:0] calc_hi,
  input logic [23:0] stored_code,
  input logic        res_valid,
  input logic [1:0]  res_status,
  input logic [8:0]  res_byte,
  input logic [7:0]  res_mask,
  input logic        s_valid,
  input logic        s_ready,
  input logic [7:0]  s_data,
  input logic        m_valid,
  input logic        m_ready,
  input logic [7:0]  m_data
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> res_valid); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |=> !res_valid); // R2
  AST_MATCH_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && stored_code == ~{calc_hi, calc_lo}) |=> res_status == 2'b00); // R3
  AST_FIX_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'b01) |-> $countones(res_mask) == 1); // R4
  AST_SINGLE_BIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && $countones(stored_code ^ ~{calc_hi, calc_lo}) == 1)
      |=> (res_status == 2'b10 && res_byte == 9'd0 && res_mask == 8'd0)); // R6
  AST_NOFIX_ZERO_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'b11) |-> (res_byte == 9'd0 && res_mask == 8'd0)); // R7
  AST_PASS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (s_ready == m_ready && m_valid == s_valid)); // R9
endmodule

bind ecc1_corrector ecc1_corrector_chk chk_i (.*);

// File: tb/ecc1_corrector_tb_top.sv
`timescale 1ns/1ps
module ecc1_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        code_valid = 1'b0;
  logic [11:0] calc_lo = '0, calc_hi = '0;
  logic [23:0] stored_code = '0;
  logic        s_valid = 1'b0, m_ready = 1'b0;
  logic [7:0]  s_data = '0;
  logic        res_valid, s_ready, m_valid;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [7:0]  res_mask, m_data;
  logic        sm_res_valid, sm_s_ready, sm_m_valid;
  logic [1:0]  sm_res_status;
  logic [8:0]  sm_res_byte;
  logic [7:0]  sm_res_mask, sm_m_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc1_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .calc_lo(calc_lo),
    .calc_hi(calc_hi), .stored_code(stored_code), .res_valid(res_valid),
    .res_status(res_status), .res_byte(res_byte), .res_mask(res_mask),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  ecc1_corrector #(.BLOCK_BYTES(256)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .calc_lo(calc_lo),
    .calc_hi(calc_hi), .stored_code(stored_code), .res_valid(sm_res_valid),
    .res_status(sm_res_status), .res_byte(sm_res_byte), .res_mask(sm_res_mask),
    .s_valid(s_valid), .s_ready(sm_s_ready), .s_data(s_data),
    .m_valid(sm_m_valid), .m_ready(m_ready), .m_data(sm_m_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // apply one code pair; returns at the negedge where the result is visible
  task automatic apply(logic [11:0] lo, logic [11:0] hi, logic [23:0] stored);
    @(negedge clk);
    calc_lo = lo; calc_hi = hi; stored_code = stored; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  function automatic logic [23:0] code_of(logic [11:0] lo, logic [11:0] hi);
    return ~{hi, lo};
  endfunction

  // diff with complementary halves pointing at byte idx, bit b
  function automatic logic [23:0] data_diff(logic [8:0] idx, logic [2:0] b);
    logic [11:0] h;
    h = {idx, b};
    return {h, ~h};
  endfunction

  // stream n bytes; byte fix_pos expected XOR fmask; stall before each byte if bp
  task automatic stream(int n, int fix_pos, logic [7:0] fmask, bit bp, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(i * 7 + 3);
      if (bp && (i % 2 == 0)) begin
        @(negedge clk);
        s_valid = 1'b1; s_data = d; m_ready = 1'b0;
        #0.5;
        chk("R9", "s_ready low under stall", 32'(s_ready), 32'd0);
        chk("R9", "m_valid follows s_valid", 32'(m_valid), 32'd1);
      end
      @(negedge clk);
      s_valid = 1'b1; s_data = d; m_ready = 1'b1;
      #0.5;
      chk(req, $sformatf("byte %0d", i), 32'(m_data),
          32'((i == fix_pos) ? (d ^ fmask) : d));
    end
    @(negedge clk);
    s_valid = 1'b0; m_ready = 1'b0;
  endtask

  task automatic t_reset();
    #0.5;
    chk("R10", "res_valid in reset", 32'(res_valid), 32'd0);
    chk("R10", "res_status in reset", 32'(res_status), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "res_valid after reset", 32'(res_valid), 32'd0);
    chk("R2", "no result without request", 32'(res_valid), 32'd0);
    stream(4, -1, 8'h00, 1'b0, "R10");
  endtask

  task automatic t_clean();
    logic [7:0] b0, b1, b2;
    logic [23:0] c;
    c  = code_of(12'h3B1, 12'hA5C);
    b0 = c[7:0]; b1 = c[15:8]; b2 = c[23:16];
    apply(12'h3B1, 12'hA5C, {b2, b1, b0});
    chk("R2", "result strobe", 32'(res_valid), 32'd1);
    chk("R1", "packed order clean", 32'(res_status), 32'd0);
    chk("R3", "clean status", 32'(res_status), 32'd0);
    chk("R3", "clean location", 32'({res_byte, res_mask}), 32'd0);
    @(negedge clk);
    chk("R2", "strobe one cycle", 32'(res_valid), 32'd0);
    // erased page: raw parity zero, stored all ones
    apply(12'h000, 12'h000, 24'hFFFFFF);
    chk("R1", "erased page clean", 32'(res_status), 32'd0);
  endtask

  task automatic t_fix_low();
    logic [23:0] c;
    c = code_of(12'h3B1, 12'hA5C);
    apply(12'h3B1, 12'hA5C, c ^ data_diff(9'd5, 3'd3));
    chk("R4", "status fixed", 32'(res_status), 32'd1);
    chk("R4", "byte index", 32'(res_byte), 32'd5);
    chk("R4", "bit mask", 32'(res_mask), 32'h08);
    stream(12, 5, 8'h08, 1'b1, "R8");
  endtask

  task automatic t_fix_high();
    logic [23:0] c;
    c = code_of(12'h0F0, 12'h123);
    apply(12'h0F0, 12'h123, c ^ data_diff(9'd511, 3'd7));
    chk("R4", "status fixed top byte", 32'(res_status), 32'd1);
    chk("R4", "byte index top", 32'(res_byte), 32'd511);
    chk("R4", "bit mask top", 32'(res_mask), 32'h80);
    chk("R5", "small block out of range", 32'(sm_res_status), 32'd3);
    chk("R5", "small block location zero", 32'({sm_res_byte, sm_res_mask}), 32'd0);
    stream(512, 511, 8'h80, 1'b0, "R8");
  endtask

  task automatic t_code_err();
    logic [23:0] c;
    c = code_of(12'h555, 12'hAAA);
    apply(12'h555, 12'hAAA, c ^ 24'h000001);
    chk("R6", "code bit 0 status", 32'(res_status), 32'd2);
    chk("R6", "code bit 0 location", 32'({res_byte, res_mask}), 32'd0);
    stream(4, -1, 8'h00, 1'b0, "R6");
    apply(12'h555, 12'hAAA, c ^ 24'h800000);
    chk("R6", "code bit 23 status", 32'(res_status), 32'd2);
  endtask

  task automatic t_uncorr();
    logic [23:0] c;
    c = code_of(12'h777, 12'h111);
    apply(12'h777, 12'h111, c ^ 24'h000003);
    chk("R7", "two bits status", 32'(res_status), 32'd3);
    chk("R7", "two bits location", 32'({res_byte, res_mask}), 32'd0);
    apply(12'h777, 12'h111, c ^ 24'h00F00F);
    chk("R7", "equal halves status", 32'(res_status), 32'd3);
    stream(3, -1, 8'h00, 1'b0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean();
    t_fix_low();
    t_fix_high();
    t_code_err();
    t_uncorr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule